// File: doc/BRIEF.md
# Interrupt Ring Entry Decoder

This block reads entries out of a circular interrupt ring that another agent fills. Whenever its own byte read pointer differs from the writer's pointer, it reads the four 32-bit words of the next 16-byte entry through a ring read port with one cycle of latency. It then pulls out the source id, source data, ring id, VMID and PASID fields. Entries whose source id marks a virtual-memory fault, and which carry a non-zero PASID, must obtain a credit grant before they may pass. A denied entry is skipped and produces no output. Every other entry goes to a decoded-entry stream with valid/ready handshaking. The read pointer is published continuously so the writer can reclaim space.

When the writer reports that the ring overflowed, the decoder discards the backlog. It resumes at the oldest entry that was not overwritten, which is the slot just past the write pointer, and it sends one clear pulse back to the writer. Fault policy beyond the credit query is left to the consumer of the stream.

Top module: `irq_ring_decoder`

## Requirements
- R1: After reset the read pointer is 0 and out_valid_o, cred_req_o, rd_en_o and ovf_clr_o are all low.
- R2: While the read pointer equals the write pointer, no ring read is issued and no entry is emitted. The comparison uses the write pointer's low log2(RING_BYTES) bits with bit 0 cleared.
- R3: An entry is fetched with four single-cycle reads at word addresses rptr>>2 through (rptr>>2)+3, modulo the ring depth. Read data is expected one cycle after rd_en_o.
- R4: Decoded fields are as follows. The source id is word 0 bits [7:0], and the source data is word 1 bits [27:0]. The ring id, VMID and PASID are word 2 bits [7:0], [15:8] and [31:16]. Every other bit is ignored.
- R5: An entry whose source id is neither 146 nor 147 is emitted without a credit query, whatever its PASID.
- R6: An entry with source id 146 or 147 and PASID 0 is emitted without a credit query.
- R7: An entry with source id 146 or 147 and a non-zero PASID raises cred_req_o with that PASID on cred_pasid_o until cred_ack_i. A high cred_grant_i at the acknowledge lets the entry be emitted.
- R8: A credit query acknowledged with cred_grant_i low drops the entry. There is no output, and the read pointer still advances by 16.
- R9: While out_valid_o is high and out_ready_i is low, the output fields and the read pointer hold. After acceptance the read pointer advances by 16.
- R10: When wptr_i bit 0 (the overflow flag) is set while idle, the read pointer becomes (clean wptr + 16) mod RING_BYTES, and ovf_clr_o pulses for exactly one cycle. There is one pulse per assertion of the flag, and nothing is fetched while the flag stays set.
- R11: Outside an overflow, the read pointer only ever moves forward by 16 bytes, and it wraps modulo RING_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wptr_i | input | WPTR_W | Writer byte pointer; bit 0 is the overflow flag |
| rd_en_o | output | 1 | Ring read strobe |
| rd_addr_o | output | log2(RING_BYTES)-2 | Ring word address |
| rd_data_i | input | 32 | Ring read data, one cycle after rd_en_o |
| cred_req_o | output | 1 | Credit query pending |
| cred_pasid_o | output | 16 | PASID being queried |
| cred_ack_i | input | 1 | Credit query answered |
| cred_grant_i | input | 1 | Credit granted, valid with cred_ack_i |
| out_valid_o | output | 1 | Decoded entry valid |
| out_ready_i | input | 1 | Consumer accepts entry |
| out_src_id_o | output | 8 | Source id |
| out_src_data_o | output | 28 | Source data |
| out_ring_id_o | output | 8 | Ring id |
| out_vmid_o | output | 8 | VMID |
| out_pasid_o | output | 16 | PASID |
| rptr_o | output | log2(RING_BYTES) | Published byte read pointer |
| ovf_clr_o | output | 1 | One-cycle overflow clear pulse |

## Verification
Several properties are checked on every cycle:
- Output fields and the read pointer hold under backpressure.
- The clear pulse lasts a single cycle.
- Each credit query carries a fault source id and a non-zero PASID.
- A denial never leads to an emitted entry.
- Outside overflow, every pointer move is exactly one 16-byte step.
- No read is issued in the cycle after the block saw an empty ring while idle.

Some behaviour can only be shown by the bench's scenarios, because it depends on contents the bench chose:
- that the field slices pick the right bits out of words filled with junk in the reserved positions;
- which source ids trigger a query;
- the exact skip target after overflow;
- the wrap from the last slot to address 0.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;

  localparam int unsigned DW_PER_ENTRY = 4;
  localparam int unsigned ENTRY_BYTES  = 16;
  localparam int unsigned DWORD_W      = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SCREEN,
    ST_CREDIT,
    ST_EMIT,
    ST_ADV
  } ring_state_e;

  typedef struct packed {
    logic [7:0]  src_id;
    logic [27:0] src_data;
    logic [7:0]  ring_id;
    logic [7:0]  vmid;
    logic [15:0] pasid;
  } iv_entry_t;

endpackage

// File: rtl/iv_fetch_buf.sv
module iv_fetch_buf #(
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned IDX_W  = $clog2(N_WORDS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cap_en_i,
  input  logic [IDX_W-1:0]                cap_idx_i,
  input  logic [WORD_W-1:0]               data_i,
  output logic [N_WORDS-1:0][WORD_W-1:0]  words_o
);

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        words_o[g] <= '0;
      end else if (cap_en_i && (cap_idx_i == IDX_W'(g))) begin
        words_o[g] <= data_i;
      end
    end
  end

endmodule

// File: rtl/iv_fields.sv
module iv_fields
  import irq_ring_pkg::*;
#(
  parameter logic [7:0] FAULT_ID_A = 8'd146,
  parameter logic [7:0] FAULT_ID_B = 8'd147
) (
  input  logic [DW_PER_ENTRY-1:0][DWORD_W-1:0] words_i,
  output iv_entry_t                            entry_o,
  output logic                                 is_fault_o
);

  always_comb begin
    entry_o.src_id   = words_i[0][7:0];
    entry_o.src_data = words_i[1][27:0];
    entry_o.ring_id  = words_i[2][7:0];
    entry_o.vmid     = words_i[2][15:8];
    entry_o.pasid    = words_i[2][31:16];
    is_fault_o       = (entry_o.src_id == FAULT_ID_A) || (entry_o.src_id == FAULT_ID_B);
  end

endmodule

// File: rtl/irq_ring_decoder.sv
module irq_ring_decoder
  import irq_ring_pkg::*;
#(
  parameter int unsigned RING_BYTES = 1024,
  parameter int unsigned WPTR_W     = 32,
  parameter int unsigned OVF_BIT    = 0,
  parameter logic [7:0]  FAULT_ID_A = 8'd146,
  parameter logic [7:0]  FAULT_ID_B = 8'd147,
  localparam int unsigned PTR_W     = $clog2(RING_BYTES),
  localparam int unsigned WADDR_W   = PTR_W - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WPTR_W-1:0]  wptr_i,
  output logic               rd_en_o,
  output logic [WADDR_W-1:0] rd_addr_o,
  input  logic [31:0]        rd_data_i,
  output logic               cred_req_o,
  output logic [15:0]        cred_pasid_o,
  input  logic               cred_ack_i,
  input  logic               cred_grant_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [7:0]         out_src_id_o,
  output logic [27:0]        out_src_data_o,
  output logic [7:0]         out_ring_id_o,
  output logic [7:0]         out_vmid_o,
  output logic [15:0]        out_pasid_o,
  output logic [PTR_W-1:0]   rptr_o,
  output logic               ovf_clr_o
);

  localparam int unsigned CNT_W = $clog2(DW_PER_ENTRY + 1);
  localparam int unsigned IDX_W = $clog2(DW_PER_ENTRY);
  localparam logic [CNT_W-1:0] FETCH_LAST = CNT_W'(DW_PER_ENTRY);
  localparam logic [PTR_W-1:0] STEP       = PTR_W'(ENTRY_BYTES);

  ring_state_e      state_q;
  logic [PTR_W-1:0] rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_clr_q;
  logic             ovf_hold_q;

  logic             ovf_flag;
  logic [PTR_W-1:0] wp_clean;
  logic [PTR_W-1:0] ovf_target;

  logic [DW_PER_ENTRY-1:0][DWORD_W-1:0] words;
  iv_entry_t        entry;
  logic             is_fault;
  logic             cap_en;
  logic [IDX_W-1:0] cap_idx;

  always_comb begin
    ovf_flag          = wptr_i[OVF_BIT];
    wp_clean          = wptr_i[PTR_W-1:0];
    wp_clean[OVF_BIT] = 1'b0;
    ovf_target        = wp_clean + STEP;
  end

  // Reads go out for cnt 0..3; data for word cnt-1 lands while cnt is 1..4
  assign rd_en_o   = (state_q == ST_FETCH) && (cnt_q < FETCH_LAST);
  assign rd_addr_o = rptr_q[PTR_W-1:2] + WADDR_W'(cnt_q[IDX_W-1:0]);
  assign cap_en    = (state_q == ST_FETCH) && (cnt_q != '0);
  assign cap_idx   = IDX_W'(cnt_q - CNT_W'(1));

  iv_fetch_buf #(
    .N_WORDS (DW_PER_ENTRY),
    .WORD_W  (DWORD_W)
  ) u_fetch_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_en_i  (cap_en),
    .cap_idx_i (cap_idx),
    .data_i    (rd_data_i),
    .words_o   (words)
  );

  iv_fields #(
    .FAULT_ID_A (FAULT_ID_A),
    .FAULT_ID_B (FAULT_ID_B)
  ) u_fields (
    .words_i    (words),
    .entry_o    (entry),
    .is_fault_o (is_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rptr_q     <= '0;
      cnt_q      <= '0;
      ovf_clr_q  <= 1'b0;
      ovf_hold_q <= 1'b0;
    end else begin
      ovf_clr_q <= 1'b0;
      if (!ovf_flag) ovf_hold_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ovf_flag) begin
            if (!ovf_hold_q) begin
              rptr_q     <= ovf_target;
              ovf_clr_q  <= 1'b1;
              ovf_hold_q <= 1'b1;
            end
          end else if (rptr_q != wp_clean) begin
            state_q <= ST_FETCH;
            cnt_q   <= '0;
          end
        end
        ST_FETCH: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == FETCH_LAST) state_q <= ST_SCREEN;
        end
        ST_SCREEN: state_q <= (is_fault && (entry.pasid != '0)) ? ST_CREDIT : ST_EMIT;
        ST_CREDIT: if (cred_ack_i) state_q <= cred_grant_i ? ST_EMIT : ST_ADV;
        ST_EMIT:   if (out_ready_i) state_q <= ST_ADV;
        ST_ADV: begin
          rptr_q  <= rptr_q + STEP;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cred_req_o     = (state_q == ST_CREDIT);
  assign cred_pasid_o   = entry.pasid;
  assign out_valid_o    = (state_q == ST_EMIT);
  assign out_src_id_o   = entry.src_id;
  assign out_src_data_o = entry.src_data;
  assign out_ring_id_o  = entry.ring_id;
  assign out_vmid_o     = entry.vmid;
  assign out_pasid_o    = entry.pasid;
  assign rptr_o         = rptr_q;
  assign ovf_clr_o      = ovf_clr_q;

  AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && rptr_q == wp_clean) |=> !rd_en_o); // R2

  AST_QUERY_IS_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cred_req_o |-> ((out_src_id_o == FAULT_ID_A || out_src_id_o == FAULT_ID_B)
                    && cred_pasid_o != '0)); // R7

  AST_DENY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cred_req_o && cred_ack_i && !cred_grant_i) |=> !out_valid_o); // R8

  AST_HOLD_UNDER_BP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_src_id_o)
      && $stable(out_src_data_o) && $stable(out_pasid_o) && $stable(rptr_o))); // R9

  AST_OVF_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr_o |=> !ovf_clr_o); // R10

  AST_RPTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rptr_q != $past(rptr_q)) && !ovf_clr_o) |-> (rptr_q == $past(rptr_q) + STEP)); // R11

endmodule

// File: tb/irq_ring_decoder_bench.sv
`timescale 1ns/1ps
module irq_ring_decoder_bench;

  localparam int unsigned RING_BYTES = 1024;
  localparam int unsigned PTR_W      = 10;
  localparam int unsigned WADDR_W    = 8;
  localparam int unsigned NV         = 8;

  typedef struct packed {
    logic [7:0]  id;
    logic [27:0] data;
    logic [7:0]  ring;
    logic [7:0]  vmid;
    logic [15:0] pasid;
    logic        grant;
    logic        exp_q;
    logic        exp_e;
  } vec_t;

  // R5 R6 R7 R8 stimulus and expectations
  localparam vec_t VECS [NV] = '{
    '{8'd10,  28'h0123456, 8'h01, 8'h02, 16'h0000, 1'b0, 1'b0, 1'b1},
    '{8'd146, 28'hABCDEF0, 8'h11, 8'h22, 16'h0000, 1'b0, 1'b0, 1'b1},
    '{8'd147, 28'h7654321, 8'h33, 8'h44, 16'h0005, 1'b1, 1'b1, 1'b1},
    '{8'd146, 28'h0000001, 8'h55, 8'h66, 16'h0007, 1'b0, 1'b1, 1'b0},
    '{8'd255, 28'hFFFFFFF, 8'hFF, 8'h01, 16'h0009, 1'b0, 1'b0, 1'b1},
    '{8'd145, 28'h1111111, 8'h02, 8'h03, 16'h1234, 1'b0, 1'b0, 1'b1},
    '{8'd148, 28'h2222222, 8'h04, 8'h05, 16'hBEEF, 1'b0, 1'b0, 1'b1},
    '{8'd147, 28'h3333333, 8'h06, 8'h07, 16'hFFFF, 1'b0, 1'b1, 1'b0}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [31:0]        wptr = '0;
  logic               rd_en;
  logic [WADDR_W-1:0] rd_addr;
  logic [31:0]        rd_data;
  logic               cred_req;
  logic [15:0]        cred_pasid;
  logic               cred_ack = 1'b0;
  logic               cred_grant = 1'b0;
  logic               out_valid;
  logic               out_ready = 1'b0;
  logic [7:0]         src_id;
  logic [27:0]        src_data;
  logic [7:0]         ring_id;
  logic [7:0]         vmid;
  logic [15:0]        pasid;
  logic [PTR_W-1:0]   rptr;
  logic               ovf_clr;

  logic [31:0] mem [RING_BYTES/4];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int wp     = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  irq_ring_decoder #(.RING_BYTES(RING_BYTES)) u_irq_ring_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wptr_i(wptr),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .cred_req_o(cred_req), .cred_pasid_o(cred_pasid),
    .cred_ack_i(cred_ack), .cred_grant_i(cred_grant),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_src_id_o(src_id), .out_src_data_o(src_data), .out_ring_id_o(ring_id),
    .out_vmid_o(vmid), .out_pasid_o(pasid), .rptr_o(rptr), .ovf_clr_o(ovf_clr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int bp);
    int base = wp >> 2;
    int tgt;
    int nrd = 0, first_addr = -1, waited = 0;
    bit seen_q = 0, seen_e = 0, hold_ok = 1;
    logic [15:0] qp = '0;
    logic [PTR_W-1:0] rp_hold = '0;
    mem[base]     = {24'h5A5A5A, v.id};
    mem[base + 1] = {4'hF, v.data};
    mem[base + 2] = {v.pasid, v.vmid, v.ring};
    mem[base + 3] = 32'hDEADBEEF;
    tgt = (wp + 16) % RING_BYTES;
    wp  = tgt;
    wptr = 32'(wp);
    for (int c = 0; c < 80 && !(int'(rptr) == tgt && seen_e == v.exp_e); c++) begin
      @(negedge clk);
      out_ready = 1'b0;
      if (rd_en) begin
        if (nrd == 0) first_addr = int'(rd_addr);
        nrd++;
      end
      if (cred_req && !cred_ack) begin
        seen_q = 1; qp = cred_pasid; cred_ack = 1'b1; cred_grant = v.grant;
      end else begin
        cred_ack = 1'b0; cred_grant = 1'b0;
      end
      if (out_valid) begin
        if (waited == 0) rp_hold = rptr;
        if (rptr != rp_hold) hold_ok = 0;
        if (waited >= bp) begin
          seen_e = 1;
          out_ready = 1'b1;
          chk(src_id == v.id, "R4 src_id", src_id, v.id);
          chk(src_data == v.data, "R4 src_data", src_data, v.data);
          chk({pasid, vmid, ring_id} == {v.pasid, v.vmid, v.ring}, "R4 pasid/vmid/ring",
              {pasid, vmid, ring_id}, {v.pasid, v.vmid, v.ring});
        end
        waited++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0; cred_ack = 1'b0;
    chk(nrd == 4 && first_addr == (base % (RING_BYTES/4)), "R3 fetch reads", nrd, 4);
    chk(seen_q == v.exp_q, "R5/R7 query issued", seen_q, v.exp_q);
    if (v.exp_q) chk(qp == v.pasid, "R7 query pasid", qp, v.pasid);
    chk(seen_e == v.exp_e, "R8 emitted", seen_e, v.exp_e);
    chk(int'(rptr) == tgt, "R11 rptr advance", rptr, tgt);
    if (bp > 0) chk(hold_ok && waited > bp, "R9 hold under backpressure", waited, bp + 1);
  endtask

  initial begin
    for (int i = 0; i < RING_BYTES/4; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(rptr == 0 && !out_valid && !cred_req && !rd_en && !ovf_clr, "R1 reset state",
        {rptr, out_valid, cred_req, rd_en, ovf_clr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 0);
    run_vec(VECS[0], 5); // R9 backpressure

    begin : idle_chk
      int nrd = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (rd_en || out_valid) nrd++;
      end
      chk(nrd == 0, "R2 idle when equal", nrd, 0);
    end

    begin : ovf_chk
      int pulses = 0, nrd = 0;
      wptr = 32'(992) | 32'd1;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (ovf_clr) pulses++;
        if (rd_en) nrd++;
      end
      chk(pulses == 1, "R10 single clear pulse", pulses, 1);
      chk(nrd == 0, "R10 no fetch while flagged", nrd, 0);
      chk(rptr == 10'd1008, "R10 skip target", rptr, 1008);
      wp = 1008;
      wptr = 32'(wp);
      repeat (3) @(negedge clk);
      chk(rptr == 10'd1008 && !ovf_clr, "R10 flag drop no effect", rptr, 1008);
    end

    run_vec(VECS[2], 0); // R11 wrap to 0
    chk(rptr == 0, "R11 wrap to zero", rptr, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule